// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block controls one switchable logic island. On command it steps the island through a fixed power-down or power-up order. The outputs it drives are the main power-switch control (sleep), output isolation, a group of memory power-down fields, a reset for the domain and its clock enable. Requests arrive as single-cycle pulses. The block answers each one with a `busy_o` level for as long as a sequence runs and a one-cycle `done_o` pulse when the request has been served. A shutdown input forces a domain that is powered into the power-down order.

The waits between steps are counted in clock cycles. A short wait goes between the switch step and the memory step, and again between the memory step and the isolation step. A long settle wait follows isolation before the clocks stop. Two parameters pick the variant. The first removes the switch and isolation steps for a domain that has memory controls only. The second removes the clock step for a domain that has no clocks. When a domain with a switch and clocks finds itself already powered at start-up, it comes up powered and stays on: plain off requests no longer change it.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset, with `boot_on_i` low, `sleep_o`, `iso_o`, `dom_rst_o` and every bit of `mem_pd_o` are 1, and `clk_en_o`, `busy_o`, `done_o` and `pwr_on_o` are 0.
- R2: Power-down order: `sleep_o` rises on the clock edge that samples the request. `mem_pd_o` goes to all ones SHORT_WAIT cycles later. `iso_o` rises SHORT_WAIT cycles after that.
- R3: With clocks present, `clk_en_o` falls exactly LONG_WAIT cycles after `iso_o` rises, and `done_o` pulses on that same edge. Without clocks, `done_o` pulses on the edge where `iso_o` would rise, and `clk_en_o` stays 0 throughout.
- R4: Power-up order: `sleep_o` falls on the clock edge that samples the request. `mem_pd_o` clears SHORT_WAIT cycles later. SHORT_WAIT cycles after that, `dom_rst_o` is 1. `iso_o` falls one cycle later and `dom_rst_o` falls the cycle after that. `clk_en_o` rises one cycle later, together with `done_o`.
- R5: With HAS_SWITCH=0, `sleep_o` and `iso_o` stay 1. The memory step and both short waits still run, so `done_o` comes 2*SHORT_WAIT+3 edges after an on request and 2*SHORT_WAIT edges after an off request. `pwr_on_o` is 1 exactly when the memory fields are cleared.
- R6: `mem_pd_o` holds MEM_BANKS fields of 2 bits each. All fields change on the same edge and always hold either all zeros or all ones.
- R7: With HAS_SWITCH=1, `pwr_on_o` is the inverse of `sleep_o`.
- R8: A `shutdown_i` pulse starts the power-down order only when the domain is powered, even when it is held always-on. On a domain that is off it produces no `done_o` and changes no output.
- R9: If `boot_on_i` is 1 when reset ends, and the domain has both a switch and clocks, the domain comes up one edge later with `sleep_o`, `iso_o`, `mem_pd_o` and `dom_rst_o` at 0, `clk_en_o` at 1 and `always_on_o` at 1. An off request then completes at once with `done_o` and changes no output. A power-down clears `always_on_o`.
- R10: A request sampled while a sequence runs is held and starts on the edge after that sequence's `done_o`. A later request replaces an earlier one, and a held shutdown outranks either. When on and off requests are sampled on the same edge, the on request wins.
- R11: When the domain is idle, a request for the state it is already in raises `done_o` on the sampling edge, and `busy_o` stays 0.
- R12: `busy_o` is 1 from the edge that starts a sequence until the edge that raises `done_o`. `done_o` lasts one cycle per completion and is never 1 while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_on_i | input | 1 | Domain found powered at start-up; sampled on the first edge after reset |
| on_req_i | input | 1 | Power-up request pulse |
| off_req_i | input | 1 | Power-down request pulse |
| shutdown_i | input | 1 | Forced power-down pulse |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| pwr_on_o | output | 1 | Domain powered status |
| always_on_o | output | 1 | Domain locked on after a powered start-up |
| sleep_o | output | 1 | Power-switch control, 1 = switched off |
| iso_o | output | 1 | Output isolation enable |
| mem_pd_o | output | 2*MEM_BANKS | Memory power-down fields, 1 = powered down |
| dom_rst_o | output | 1 | Domain reset, active high |
| clk_en_o | output | 1 | Domain clock enable |

## Verification
Every control output is a register. The first step of a sequence therefore shows up just after the edge that samples the request. Every later step is due a fixed number of edges after that first step: SHORT_WAIT, 2*SHORT_WAIT, then +1, +2 and +3 for isolation release, reset release and clock enable, or 2*SHORT_WAIT+LONG_WAIT for the clock stop. The bench sets every input on a falling edge and reads every output on a falling edge, an exact number of cycles after the sampling edge. It checks each output one cycle before its due edge, where the output must not have moved yet, and again on the due edge, where it must have moved. That pins down both the order and the spacing. For held requests, the bench counts from the completion edge of the running sequence.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [3:0] {
    ST_INIT,
    ST_OFF,
    ST_ON,
    ST_DN_W1,
    ST_DN_W2,
    ST_DN_W3,
    ST_UP_W1,
    ST_UP_W2,
    ST_UP_ISO,
    ST_UP_RST,
    ST_UP_CLK
  } pds_state_e;
endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int HAS_SWITCH = 1,
  parameter int HAS_CLOCKS = 1,
  parameter int SHORT_WAIT = 4,
  parameter int LONG_WAIT  = 16,
  parameter int TW         = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boot_on_i,
  input  logic          on_req_i,
  input  logic          off_req_i,
  input  logic          shutdown_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          always_on_o,
  output logic          sleep_o,
  output logic          iso_o,
  output logic          mem_pd_o,
  output logic          dom_rst_o,
  output logic          clk_en_o
);
  localparam bit SW = (HAS_SWITCH != 0);
  localparam bit CK = (HAS_CLOCKS != 0);

  pds_state_e state_q;
  logic sleep_q, iso_q, mem_q, drst_q, clk_q, aon_q, done_q;
  logic pend_v_q, pend_on_q, pend_f_q;
  logic idle, go_v, go_on, go_f;
  logic start_dn, start_up, ack_now;

  assign idle = (state_q == ST_OFF) || (state_q == ST_ON);

  // shutdown first, then held shutdown, then fresh requests, then held request
  always_comb begin
    go_v = 1'b0; go_on = 1'b0; go_f = 1'b0;
    if (shutdown_i)                begin go_v = 1'b1; go_f = 1'b1; end
    else if (pend_v_q && pend_f_q) begin go_v = 1'b1; go_f = 1'b1; end
    else if (on_req_i)             begin go_v = 1'b1; go_on = 1'b1; end
    else if (off_req_i)            begin go_v = 1'b1; end
    else if (pend_v_q)             begin go_v = 1'b1; go_on = pend_on_q; end
  end

  always_comb begin
    start_dn = 1'b0; start_up = 1'b0; ack_now = 1'b0;
    if (idle && go_v) begin
      if (go_f)                                   start_dn = (state_q == ST_ON);
      else if (go_on)                             begin
        if (state_q == ST_ON) ack_now = 1'b1; else start_up = 1'b1;
      end
      else if ((state_q == ST_OFF) || aon_q)      ack_now = 1'b1;
      else                                        start_dn = 1'b1;
    end
  end

  always_comb begin
    tmr_load_o = start_dn || start_up
              || (tmr_zero_i && ((state_q == ST_DN_W1) || (state_q == ST_UP_W1)))
              || (tmr_zero_i && (state_q == ST_DN_W2) && CK);
    tmr_val_o  = (state_q == ST_DN_W2) ? TW'(LONG_WAIT - 1) : TW'(SHORT_WAIT - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_INIT;
      sleep_q   <= 1'b1;
      iso_q     <= 1'b1;
      mem_q     <= 1'b1;
      drst_q    <= 1'b1;
      clk_q     <= 1'b0;
      aon_q     <= 1'b0;
      done_q    <= 1'b0;
      pend_v_q  <= 1'b0;
      pend_on_q <= 1'b0;
      pend_f_q  <= 1'b0;
    end else begin
      done_q <= ack_now;
      if (idle) begin
        pend_v_q <= 1'b0;
        pend_f_q <= 1'b0;
      end else if (shutdown_i || on_req_i || off_req_i) begin
        pend_v_q <= 1'b1;
        if (shutdown_i) begin
          pend_f_q  <= 1'b1;
          pend_on_q <= 1'b0;
        end else begin
          pend_on_q <= on_req_i;
        end
      end
      if (start_dn) begin
        if (SW) sleep_q <= 1'b1;
        aon_q   <= 1'b0;
        state_q <= ST_DN_W1;
      end
      if (start_up) begin
        if (SW) sleep_q <= 1'b0;
        state_q <= ST_UP_W1;
      end
      unique case (state_q)
        ST_INIT: begin
          if (boot_on_i && SW) begin
            state_q <= ST_ON;
            sleep_q <= 1'b0;
            iso_q   <= 1'b0;
            mem_q   <= 1'b0;
            drst_q  <= 1'b0;
            clk_q   <= CK;
            aon_q   <= CK;
          end else begin
            state_q <= ST_OFF;
          end
        end
        ST_DN_W1: if (tmr_zero_i) begin
          mem_q   <= 1'b1;
          state_q <= ST_DN_W2;
        end
        ST_DN_W2: if (tmr_zero_i) begin
          if (SW) iso_q <= 1'b1;
          if (CK) state_q <= ST_DN_W3;
          else begin
            state_q <= ST_OFF;
            done_q  <= 1'b1;
          end
        end
        ST_DN_W3: if (tmr_zero_i) begin
          clk_q   <= 1'b0;
          state_q <= ST_OFF;
          done_q  <= 1'b1;
        end
        ST_UP_W1: if (tmr_zero_i) begin
          mem_q   <= 1'b0;
          state_q <= ST_UP_W2;
        end
        ST_UP_W2: if (tmr_zero_i) begin
          drst_q  <= 1'b1;
          state_q <= ST_UP_ISO;
        end
        ST_UP_ISO: begin
          if (SW) iso_q <= 1'b0;
          state_q <= ST_UP_RST;
        end
        ST_UP_RST: begin
          drst_q  <= 1'b0;
          state_q <= ST_UP_CLK;
        end
        ST_UP_CLK: begin
          clk_q   <= CK;
          state_q <= ST_ON;
          done_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign always_on_o = aon_q;
  assign sleep_o     = sleep_q;
  assign iso_o       = iso_q;
  assign mem_pd_o    = mem_q;
  assign dom_rst_o   = drst_q;
  assign clk_en_o    = clk_q;

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_aon_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aon_q && state_q == ST_ON && !shutdown_i && !(pend_v_q && pend_f_q))
      |=> (state_q == ST_ON));

  assert_sd_off_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && shutdown_i) |=> (state_q == ST_OFF && !done_o));
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
  parameter int HAS_SWITCH = 1,
  parameter int HAS_CLOCKS = 1,
  parameter int MEM_BANKS  = 4,
  parameter int SHORT_WAIT = 4,
  parameter int LONG_WAIT  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   boot_on_i,
  input  logic                   on_req_i,
  input  logic                   off_req_i,
  input  logic                   shutdown_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   pwr_on_o,
  output logic                   always_on_o,
  output logic                   sleep_o,
  output logic                   iso_o,
  output logic [2*MEM_BANKS-1:0] mem_pd_o,
  output logic                   dom_rst_o,
  output logic                   clk_en_o
);
  localparam int MAXW = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int TW   = $clog2(MAXW + 1) + 1;
  localparam int CW   = $clog2(LONG_WAIT + 1) + 1;

  logic          tmr_load, tmr_zero, mem_all;
  logic [TW-1:0] tmr_val;

  pds_wait_timer #(.TW(TW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  pds_fsm #(
    .HAS_SWITCH (HAS_SWITCH),
    .HAS_CLOCKS (HAS_CLOCKS),
    .SHORT_WAIT (SHORT_WAIT),
    .LONG_WAIT  (LONG_WAIT),
    .TW         (TW)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_on_i   (boot_on_i),
    .on_req_i    (on_req_i),
    .off_req_i   (off_req_i),
    .shutdown_i  (shutdown_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .always_on_o (always_on_o),
    .sleep_o     (sleep_o),
    .iso_o       (iso_o),
    .mem_pd_o    (mem_all),
    .dom_rst_o   (dom_rst_o),
    .clk_en_o    (clk_en_o)
  );

  for (genvar b = 0; b < MEM_BANKS; b++) begin : g_bank
    assign mem_pd_o[2*b +: 2] = {2{mem_all}};
  end

  if (HAS_SWITCH != 0) begin : g_stat_sw
    assign pwr_on_o = !sleep_o;
  end else begin : g_stat_mem
    assign pwr_on_o = !mem_pd_o[0];
  end

  assert_mem_group_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_pd_o == '0) || (&mem_pd_o));

  if (HAS_SWITCH != 0) begin : g_sw_chk
    logic [CW-1:0] settle_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   settle_q <= '0;
      else if (!iso_o)               settle_q <= '0;
      else if (!(&settle_q))         settle_q <= settle_q + 1'b1;
    end

    assert_iso_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(iso_o) |-> (sleep_o && (&mem_pd_o)));

    assert_rst_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dom_rst_o) |-> (!iso_o && (mem_pd_o == '0) && !sleep_o));

    assert_clk_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_en_o) |-> (!dom_rst_o && !iso_o));

    assert_clk_off_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(clk_en_o) |-> (iso_o && settle_q >= CW'(LONG_WAIT)));
  end else begin : g_mem_chk
    assert_no_switch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_o && iso_o);
  end
endmodule

// File: tb/test_pwr_dom_seq.sv
module test_pwr_dom_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  S  = 4;
  localparam int  L  = 16;
  localparam int  MB = 4;
  localparam int  MM = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_on = 1'b0, on_req = 1'b0, off_req = 1'b0, sd = 1'b0;
  logic m_on = 1'b0, m_off = 1'b0;
  logic busy, done, pwr_on, aon, sleep, iso, drst, clk_en;
  logic [2*MB-1:0] mem;
  logic m_busy, m_done, m_pwr_on, m_aon, m_sleep, m_iso, m_drst, m_clk_en;
  logic [2*MM-1:0] m_mem;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_dom_seq #(.HAS_SWITCH(1), .HAS_CLOCKS(1), .MEM_BANKS(MB),
                .SHORT_WAIT(S), .LONG_WAIT(L)) i_pwr_dom_seq (
    .clk_i(clk), .rst_ni(rst_n), .boot_on_i(boot_on), .on_req_i(on_req),
    .off_req_i(off_req), .shutdown_i(sd), .busy_o(busy), .done_o(done),
    .pwr_on_o(pwr_on), .always_on_o(aon), .sleep_o(sleep), .iso_o(iso),
    .mem_pd_o(mem), .dom_rst_o(drst), .clk_en_o(clk_en));

  pwr_dom_seq #(.HAS_SWITCH(0), .HAS_CLOCKS(0), .MEM_BANKS(MM),
                .SHORT_WAIT(S), .LONG_WAIT(L)) i_pwr_dom_seq_mem (
    .clk_i(clk), .rst_ni(rst_n), .boot_on_i(1'b0), .on_req_i(m_on),
    .off_req_i(m_off), .shutdown_i(1'b0), .busy_o(m_busy), .done_o(m_done),
    .pwr_on_o(m_pwr_on), .always_on_o(m_aon), .sleep_o(m_sleep), .iso_o(m_iso),
    .mem_pd_o(m_mem), .dom_rst_o(m_drst), .clk_en_o(m_clk_en));

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive for one edge; returns just after that edge
  task automatic pulse(bit a_on, bit a_off, bit a_sd, bit b_on, bit b_off);
    @(negedge clk);
    on_req = a_on; off_req = a_off; sd = a_sd; m_on = b_on; m_off = b_off;
    @(negedge clk);
    on_req = 0; off_req = 0; sd = 0; m_on = 0; m_off = 0;
  endtask

  task automatic do_reset(bit boot);
    @(negedge clk);
    boot_on = boot;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R1", "sleep", sleep, 1);
    check("R1", "iso", iso, 1);
    check("R1", "mem", mem, {2*MB{1'b1}});
    check("R1", "rst", drst, 1);
    check("R1", "clk_en", clk_en, 0);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "pwr_on", pwr_on, 0);
  endtask

  task automatic t_power_up;
    pulse(1, 0, 0, 0, 0);
    check("R4", "sleep cleared", sleep, 0);
    check("R12", "busy", busy, 1);
    check("R7", "pwr_on", pwr_on, 1);
    step(S-1);
    check("R4", "mem early", mem, {2*MB{1'b1}});
    step(1);
    check("R6", "mem cleared", mem, 0);
    check("R4", "iso held", iso, 1);
    step(S);
    check("R4", "rst asserted", drst, 1);
    check("R4", "iso before", iso, 1);
    step(1);
    check("R4", "iso released", iso, 0);
    check("R4", "rst still", drst, 1);
    step(1);
    check("R4", "rst released", drst, 0);
    check("R4", "clk not yet", clk_en, 0);
    step(1);
    check("R4", "clk on", clk_en, 1);
    check("R12", "done", done, 1);
    check("R12", "busy low", busy, 0);
    step(1);
    check("R12", "done one cycle", done, 0);
  endtask

  task automatic t_same_state;
    pulse(1, 0, 0, 0, 0);
    check("R11", "done", done, 1);
    check("R11", "busy", busy, 0);
    step(1);
    check("R11", "done drop", done, 0);
    check("R11", "sleep", sleep, 0);
  endtask

  task automatic t_power_down;
    pulse(0, 1, 0, 0, 0);
    check("R2", "sleep set", sleep, 1);
    check("R7", "pwr_on", pwr_on, 0);
    step(S-1);
    check("R2", "mem early", mem, 0);
    step(1);
    check("R2", "mem set", mem, {2*MB{1'b1}});
    step(S-1);
    check("R2", "iso early", iso, 0);
    step(1);
    check("R2", "iso set", iso, 1);
    check("R3", "clk still", clk_en, 1);
    step(L-1);
    check("R3", "clk early", clk_en, 1);
    check("R3", "done early", done, 0);
    step(1);
    check("R3", "clk off", clk_en, 0);
    check("R3", "done", done, 1);
    check("R3", "rst untouched", drst, 0);
  endtask

  task automatic t_pending;
    pulse(1, 1, 0, 0, 0);
    check("R10", "on wins", sleep, 0);
    step(2);
    pulse(0, 1, 0, 0, 0);
    check("R10", "busy while held", busy, 1);
    step(2*S+3-4);
    check("R10", "up done", done, 1);
    check("R10", "clk on", clk_en, 1);
    step(1);
    check("R10", "held off starts", sleep, 1);
    check("R10", "busy again", busy, 1);
    step(2*S+L);
    check("R10", "down done", done, 1);
    check("R10", "clk off", clk_en, 0);
  endtask

  task automatic t_shutdown;
    pulse(0, 0, 1, 0, 0);
    check("R8", "no done when off", done, 0);
    check("R8", "idle", busy, 0);
    step(1);
    check("R8", "sleep stays", sleep, 1);
    check("R8", "no done later", done, 0);
    pulse(1, 0, 0, 0, 0);
    step(2*S+3);
    check("R8", "powered", pwr_on, 1);
    pulse(0, 0, 1, 0, 0);
    check("R8", "forced down", sleep, 1);
    check("R8", "busy", busy, 1);
    step(2*S+L);
    check("R8", "down done", done, 1);
  endtask

  task automatic t_boot;
    do_reset(1'b1);
    check("R9", "sleep", sleep, 0);
    check("R9", "iso", iso, 0);
    check("R9", "mem", mem, 0);
    check("R9", "rst", drst, 0);
    check("R9", "clk", clk_en, 1);
    check("R9", "always_on", aon, 1);
    pulse(0, 1, 0, 0, 0);
    check("R9", "off acked", done, 1);
    check("R9", "sleep kept", sleep, 0);
    step(1);
    check("R9", "clk kept", clk_en, 1);
    check("R9", "idle", busy, 0);
    pulse(0, 0, 1, 0, 0);
    check("R9", "shutdown wins", sleep, 1);
    check("R9", "always_on cleared", aon, 0);
    step(2*S+L);
    check("R9", "down done", done, 1);
    check("R9", "clk off", clk_en, 0);
    boot_on = 1'b0;
  endtask

  task automatic t_mem_only;
    check("R5", "pwr_on off", m_pwr_on, 0);
    pulse(0, 0, 0, 1, 0);
    check("R5", "busy", m_busy, 1);
    check("R5", "sleep held", m_sleep, 1);
    step(S-1);
    check("R5", "mem early", m_mem, {2*MM{1'b1}});
    step(1);
    check("R5", "mem cleared", m_mem, 0);
    check("R5", "pwr_on", m_pwr_on, 1);
    step(S+2);
    check("R5", "done early", m_done, 0);
    step(1);
    check("R5", "up done", m_done, 1);
    check("R5", "iso held", m_iso, 1);
    check("R5", "clk none", m_clk_en, 0);
    pulse(0, 0, 0, 0, 1);
    step(S-1);
    check("R5", "mem early dn", m_mem, 0);
    step(1);
    check("R5", "mem set", m_mem, {2*MM{1'b1}});
    step(S-1);
    check("R5", "dn done early", m_done, 0);
    step(1);
    check("R5", "dn done", m_done, 1);
    check("R5", "sleep held dn", m_sleep, 1);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_same_state();
    t_power_down();
    t_pending();
    t_shutdown();
    t_boot();
    do_reset(1'b0);
    t_mem_only();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule